// File: doc/BRIEF.md
# On-Screen Character Overlay Generator

This block draws a text overlay on top of a television picture. It follows the incoming horizontal and vertical sync pulses. From a small video memory of character codes it looks up an 11-wide by 15-tall dot pattern in a built-in glyph table. For each dot it emits a foreground-enable flag and a 3-bit colour code. The screen is a grid of 8 character rows by 20 character columns. Colour is chosen per row. One selectable row can show a two-colour bar, which suits level indicators such as volume.

The dot-enable output halts shortly after each horizontal sync begins and resumes right after it ends. Dot counting therefore starts from the same phase on every line. A CPU write port fills the character memory and the configuration registers. Writes land in a shadow copy, and the whole copy is transferred to the display side at the next vertical sync. A frame that is being drawn never mixes old and new content.

Top module: `osd_overlay_gen`

## Requirements
- R1: The overlay window is 20 cells wide and 8 cells tall, each cell 11 dots by 15 lines. Window dot column x and window line y select cell row r = y/15 and cell column c = x/11, and the character code is read from memory address r*20+c. Within the cell, gx = x mod 11 and gy = y mod 15.
- R2: Glyph table, with gx=0 as the leftmost dot and gy=0 as the top line. Code 0 is blank. Code 1 is solid. Code 2 is the cell border (gx=0, gx=10, gy=0 or gy=14). Code 3 lights the even columns. Code 4 lights the even lines. Code 5 is the diagonal gx==gy. Code 6 is the checkerboard where gx+gy is odd. Code 7 is the left part gx<6. Codes 8 and above are blank.
- R3: A lit dot outside bar mode carries the colour of its cell row. That colour is bits [2:0] written at address 160+r.
- R4: Bar mode uses address 168, where bit 3 enables it and bits [2:0] pick the row. On that row, a lit dot with window column x below the threshold at address 169 uses the row colour. A lit dot at or beyond the threshold uses colour B, which is bits [2:0] of address 170.
- R5: dot_en is 0 after the second consecutive rising clock edge at which hsync is sampled high. It returns to 1 after the first edge at which hsync is sampled low. After reset, dot_en is 1 from the first edge with hsync low.
- R6: Dot index n is the n-th dot_en cycle of a line, counting from 0. Its pixel appears on the outputs one clock later. The horizontal window spans dots hstart to hstart+219, where hstart is at address 171. Outside this span pix_fg is 0.
- R7: The line that follows the k-th hsync rise after a vsync rise is line k-1. The vertical window spans lines vstart to vstart+119, where vstart is at address 172. Outside this span pix_fg is 0.
- R8: Bit 0 of address 173 enables the display. While it is 0, pix_fg stays 0. It is 0 after reset.
- R9: CPU writes go to a shadow copy. Memory, colours and registers used for drawing change only at a vsync rising edge, so a frame in progress is unaffected by writes.
- R10: In reset, dot_en, pix_fg and pix_color are 0. Whenever pix_fg is 0, pix_color is 0.
- R11: The pixel outputs after a cycle in which dot_en was 0 show pix_fg = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync | input | 1 | Horizontal sync, active high, at least 2 clocks long |
| vsync | input | 1 | Vertical sync, active high |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU write address (0..159 memory, 160..173 registers) |
| cpu_wdata | input | 8 | CPU write data |
| dot_en | output | 1 | Dot clock enable, gated by line timing |
| pix_fg | output | 1 | Overlay foreground enable for the current dot |
| pix_color | output | 3 | Colour code of the current dot |

## Verification
The main drawing path is first driven with a random screen of glyph codes, random row colours and a random bar threshold, with the window moved off the origin. This separates cell addressing and glyph decoding errors from colour selection errors. Directed frames then put the threshold at 0 and at a value beyond the window, with the window at the origin and at a larger offset. These frames tell the all-B bar, the all-A bar and the window edge comparisons apart. While the first frame is drawn, random writes arrive once per line, so any write that leaks into the live frame shows up as a wrong dot. Lines run before the first vsync and a final frame with the display disabled confirm that nothing is drawn while disabled.

// File: rtl/osd_pkg.sv
// Package osd_pkg
// Shared geometry, register offsets, configuration type and the glyph
// table for the overlay generator. Assumes the cell grid fits in an 8-bit
// CPU address space together with the register block.
package osd_pkg;
    localparam int ROWS    = 8;
    localparam int COLS    = 20;
    localparam int GLYPH_W = 11;
    localparam int GLYPH_H = 15;
    localparam int COLOR_W = 3;
    localparam int CODE_W  = 8;
    localparam int POS_W   = 8;
    localparam int CPU_AW  = 8;
    localparam int CPU_DW  = CODE_W;

    localparam int CELLS   = ROWS * COLS;
    localparam int CELL_AW = $clog2(CELLS);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = $clog2(COLS);
    localparam int GX_W    = $clog2(GLYPH_W);
    localparam int GY_W    = $clog2(GLYPH_H);
    localparam int WIN_W   = COLS * GLYPH_W;
    localparam int WIN_H   = ROWS * GLYPH_H;

    localparam int A_ROWCOL = CELLS;
    localparam int A_BARCTL = CELLS + ROWS;
    localparam int A_BARTHR = A_BARCTL + 1;
    localparam int A_BARCOL = A_BARCTL + 2;
    localparam int A_HSTART = A_BARCTL + 3;
    localparam int A_VSTART = A_BARCTL + 4;
    localparam int A_CTRL   = A_BARCTL + 5;

    typedef struct packed {
        logic               en;
        logic [POS_W-1:0]   hstart;
        logic [POS_W-1:0]   vstart;
        logic               bar_on;
        logic [ROW_W-1:0]   bar_row;
        logic [POS_W-1:0]   bar_thr;
        logic [COLOR_W-1:0] bar_color;
    } osd_cfg_t;

    // Sample glyph table: returns whether dot (gx, gy) of a code is lit.
    function automatic logic glyph_bit(input logic [CODE_W-1:0] code,
                                       input logic [GX_W-1:0] gx,
                                       input logic [GY_W-1:0] gy);
        logic [2:0] sel;
        sel = code[2:0];
        if (code >= CODE_W'(8)) return 1'b0;
        case (sel)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return (gx == '0) || (gy == '0) ||
                         (gx == GX_W'(GLYPH_W - 1)) || (gy == GY_W'(GLYPH_H - 1));
            3'd3: return !gx[0];
            3'd4: return !gy[0];
            3'd5: return int'(gx) == int'(gy);
            3'd6: return gx[0] ^ gy[0];
            default: return int'(gx) < (GLYPH_W + 1) / 2;
        endcase
    endfunction
endpackage

// File: rtl/osd_timing.sv
// Module osd_timing
// Derives the gated dot enable from hsync and keeps the dot and line
// counters. Assumes hsync and vsync are synchronous to clk and that each
// hsync pulse lasts at least two clocks.
module osd_timing #(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    output logic              dot_en,
    output logic [HCNT_W-1:0] hcnt,
    output logic [VCNT_W-1:0] vcnt
);
    localparam logic [HCNT_W-1:0] HCNT_MAX = '1;

    logic hs_q;
    logic line_start;

    assign line_start = hsync && !hs_q;

    // Delay hsync by one clock for edge and duration detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= hsync;
    end

    // Stop dots on the second sampled-high cycle, restart on the first low one.
    always_ff @(posedge clk) begin
        if (!rst_n) dot_en <= 1'b0;
        else        dot_en <= !(hsync && hs_q);
    end

    // Count dots since the enable came back; saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)               hcnt <= '0;
        else if (!dot_en)         hcnt <= '0;
        else if (hcnt != HCNT_MAX) hcnt <= hcnt + 1'b1;
    end

    // Count lines: vsync parks at all-ones so the first hsync gives line 0.
    always_ff @(posedge clk) begin
        if (!rst_n)          vcnt <= '1;
        else if (vsync)      vcnt <= '1;
        else if (line_start) vcnt <= vcnt + 1'b1;
    end

    // R5
    dot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && $past(hsync) && $past(rst_n)) |=> !dot_en);

    // R5
    dot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync |=> dot_en);
endmodule

// File: rtl/osd_regs.sv
// Module osd_regs
// CPU-writable shadow copy of character memory, row colours and the
// configuration block, plus the display-side copy loaded at each vsync
// rise. Assumes the CPU does not write on the vsync rising edge cycle.
module osd_regs
    import osd_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vsync,
    input  logic                          cpu_we,
    input  logic [CPU_AW-1:0]             cpu_addr,
    input  logic [CPU_DW-1:0]             cpu_wdata,
    input  logic [CELL_AW-1:0]            rd_addr,
    output logic [CODE_W-1:0]             rd_code,
    output osd_cfg_t                      cfg,
    output logic [ROWS-1:0][COLOR_W-1:0]  row_color
);
    logic [CODE_W-1:0]            vram_b [CELLS];
    logic [CODE_W-1:0]            vram_f [CELLS];
    osd_cfg_t                     cfg_b;
    logic [ROWS-1:0][COLOR_W-1:0] col_b;
    logic                         vs_q;
    logic                         frame_load;
    logic                         hit_vram;

    assign frame_load = vsync && !vs_q;
    assign hit_vram   = cpu_we && (cpu_addr < CPU_AW'(CELLS));

    // Remember vsync to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vsync;
    end

    // Shadow character memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) vram_b[i] <= '0;
        end else if (hit_vram) begin
            vram_b[CELL_AW'(cpu_addr)] <= cpu_wdata;
        end
    end

    // One shadow colour register per character row.
    for (genvar r = 0; r < ROWS; r++) begin : g_rowcol
        always_ff @(posedge clk) begin
            if (!rst_n)
                col_b[r] <= '0;
            else if (cpu_we && cpu_addr == CPU_AW'(A_ROWCOL + r))
                col_b[r] <= cpu_wdata[COLOR_W-1:0];
        end
    end

    // Shadow configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_b <= '0;
        end else if (cpu_we) begin
            if (cpu_addr == CPU_AW'(A_BARCTL)) begin
                cfg_b.bar_on  <= cpu_wdata[ROW_W];
                cfg_b.bar_row <= cpu_wdata[ROW_W-1:0];
            end
            if (cpu_addr == CPU_AW'(A_BARTHR)) cfg_b.bar_thr   <= cpu_wdata[POS_W-1:0];
            if (cpu_addr == CPU_AW'(A_BARCOL)) cfg_b.bar_color <= cpu_wdata[COLOR_W-1:0];
            if (cpu_addr == CPU_AW'(A_HSTART)) cfg_b.hstart    <= cpu_wdata[POS_W-1:0];
            if (cpu_addr == CPU_AW'(A_VSTART)) cfg_b.vstart    <= cpu_wdata[POS_W-1:0];
            if (cpu_addr == CPU_AW'(A_CTRL))   cfg_b.en        <= cpu_wdata[0];
        end
    end

    // Transfer the whole shadow to the display side at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) vram_f[i] <= '0;
            cfg       <= '0;
            row_color <= '0;
        end else if (frame_load) begin
            vram_f    <= vram_b;
            cfg       <= cfg_b;
            row_color <= col_b;
        end
    end

    // Display-side read port.
    assign rd_code = (rd_addr < CELL_AW'(CELLS)) ? vram_f[rd_addr] : '0;

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> ($stable(cfg) && $stable(row_color)));
endmodule

// File: rtl/osd_pixel.sv
// Module osd_pixel
// Maps the dot and line counters into the overlay window, fetches the
// character code, decodes the glyph dot and picks the row or bar colour.
// The result is registered once. Assumes the counters are wide enough to
// reach the far window edges.
module osd_pixel
    import osd_pkg::*;
#(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dot_en,
    input  logic [HCNT_W-1:0]             hcnt,
    input  logic [VCNT_W-1:0]             vcnt,
    input  osd_cfg_t                      cfg,
    input  logic [ROWS-1:0][COLOR_W-1:0]  row_color,
    input  logic [CODE_W-1:0]             rd_code,
    output logic [CELL_AW-1:0]            rd_addr,
    output logic                          pix_fg,
    output logic [COLOR_W-1:0]            pix_color
);
    logic [HCNT_W-1:0]  hs_ext, hx;
    logic [VCNT_W-1:0]  vs_ext, ly;
    logic               in_h, in_v;
    logic [ROW_W-1:0]   row;
    logic [COL_W-1:0]   col;
    logic [GX_W-1:0]    gx;
    logic [GY_W-1:0]    gy;
    logic               dot_on, bar_hit, fg_next;
    logic [COLOR_W-1:0] col_next;

    // Window position, cell coordinates and memory address of this dot.
    always_comb begin
        hs_ext  = HCNT_W'(cfg.hstart);
        vs_ext  = VCNT_W'(cfg.vstart);
        hx      = hcnt - hs_ext;
        ly      = vcnt - vs_ext;
        in_h    = (hcnt >= hs_ext) && (hx < HCNT_W'(WIN_W));
        in_v    = (vcnt >= vs_ext) && (ly < VCNT_W'(WIN_H));
        row     = ROW_W'(ly / VCNT_W'(GLYPH_H));
        gy      = GY_W'(ly % VCNT_W'(GLYPH_H));
        col     = COL_W'(hx / HCNT_W'(GLYPH_W));
        gx      = GX_W'(hx % HCNT_W'(GLYPH_W));
        rd_addr = CELL_AW'(row) * CELL_AW'(COLS) + CELL_AW'(col);
    end

    // Glyph dot, bar split and colour choice.
    always_comb begin
        dot_on   = glyph_bit(rd_code, gx, gy);
        bar_hit  = cfg.bar_on && (cfg.bar_row == row) &&
                   (hx >= HCNT_W'(cfg.bar_thr));
        fg_next  = dot_en && cfg.en && in_h && in_v && dot_on;
        col_next = bar_hit ? cfg.bar_color : row_color[row];
    end

    // Register the pixel; colour is forced to zero on background dots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_fg    <= 1'b0;
            pix_color <= '0;
        end else begin
            pix_fg    <= fg_next;
            pix_color <= fg_next ? col_next : '0;
        end
    end

    // R11
    gap_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> !pix_fg);

    // R8
    disabled_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !pix_fg);

    // R10
    color_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_fg |-> (pix_color == '0));

    // R6
    left_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_fg |-> ($past(hcnt) >= $past(HCNT_W'(cfg.hstart))));

    // R7
    top_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_fg |-> ($past(vcnt) >= $past(VCNT_W'(cfg.vstart))));
endmodule

// File: rtl/osd_overlay_gen.sv
// Module osd_overlay_gen
// Top of the on-screen character overlay: sync timing, CPU-side shadow
// storage with frame-aligned transfer, and the pixel path. Assumes all
// inputs are synchronous to the dot oscillator clock.
module osd_overlay_gen
    import osd_pkg::*;
#(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               cpu_we,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [CPU_DW-1:0]  cpu_wdata,
    output logic               dot_en,
    output logic               pix_fg,
    output logic [COLOR_W-1:0] pix_color
);
    logic [HCNT_W-1:0]            hcnt;
    logic [VCNT_W-1:0]            vcnt;
    logic [CELL_AW-1:0]           rd_addr;
    logic [CODE_W-1:0]            rd_code;
    osd_cfg_t                     cfg;
    logic [ROWS-1:0][COLOR_W-1:0] row_color;

    osd_timing #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .dot_en(dot_en), .hcnt(hcnt), .vcnt(vcnt)
    );

    osd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .vsync(vsync),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .rd_addr(rd_addr), .rd_code(rd_code),
        .cfg(cfg), .row_color(row_color)
    );

    osd_pixel #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_pixel (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en),
        .hcnt(hcnt), .vcnt(vcnt), .cfg(cfg), .row_color(row_color),
        .rd_code(rd_code), .rd_addr(rd_addr),
        .pix_fg(pix_fg), .pix_color(pix_color)
    );
endmodule

// File: tb/sim_osd_overlay_gen.sv
// Bench for osd_overlay_gen: drives synthetic sync, programs screens
// through the CPU port and compares every dot against a model.
module sim_osd_overlay_gen;
    localparam int LDOTS  = 236;
    localparam int NLINES = 126;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0, vsync = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       dot_en, pix_fg;
    logic [2:0] pix_color;

    int checks = 0, errors = 0, ferr = 0;
    bit done = 0;

    // Model state: shadow (b_) and display (f_) copies.
    // reg index: 0 bar ctl, 1 threshold, 2 colour B, 3 hstart, 4 vstart, 5 ctrl
    bit [7:0] b_ram [160], f_ram [160];
    bit [2:0] b_col [8],   f_col [8];
    bit [7:0] b_reg [6],   f_reg [6];

    always #2 clk = ~clk;

    osd_overlay_gen u0 (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .dot_en(dot_en), .pix_fg(pix_fg), .pix_color(pix_color)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            ferr++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit glyph(int code, int gx, int gy);
        case (code)
            0: return 0;
            1: return 1;
            2: return gx == 0 || gx == 10 || gy == 0 || gy == 14;
            3: return (gx % 2) == 0;
            4: return (gy % 2) == 0;
            5: return gx == gy;
            6: return ((gx + gy) % 2) == 1;
            7: return gx < 6;
            default: return 0;
        endcase
    endfunction

    function automatic int expect_pix(int line, int dot, output string tag);
        int ly, x, r, c;
        tag = "R8";
        if (!f_reg[5][0]) return 0;
        tag = "R7";
        if (line < int'(f_reg[4]) || line - int'(f_reg[4]) >= 120) return 0;
        tag = "R6";
        if (dot < int'(f_reg[3]) || dot - int'(f_reg[3]) >= 220) return 0;
        ly = line - int'(f_reg[4]);
        x  = dot - int'(f_reg[3]);
        r  = ly / 15;
        c  = x / 11;
        tag = "R2 R10";
        if (!glyph(int'(f_ram[r*20+c]), x % 11, ly % 15)) return 0;
        if (f_reg[0][3] && int'(f_reg[0][2:0]) == r && x >= int'(f_reg[1])) begin
            tag = "R4";
            return 8 | int'(f_reg[2][2:0]);
        end
        tag = "R1 R3";
        return 8 | int'(f_col[r]);
    endfunction

    function automatic void model_write(int a, bit [7:0] d);
        if (a < 160)      b_ram[a] = d;
        else if (a < 168) b_col[a-160] = d[2:0];
        else if (a < 174) b_reg[a-168] = d;
    endfunction

    task automatic cpu_write(int a, bit [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 8'(a); cpu_wdata = d;
        model_write(a, d);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic do_vsync();
        @(negedge clk) vsync = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) vsync = 1'b0;
        f_ram = b_ram; f_col = b_col; f_reg = b_reg;
    endtask

    // One line: 3-clock hsync, optional CPU write, then LDOTS checked dots.
    task automatic drive_line(int line, bit do_wr);
        string tag;
        int exp, act, a;
        bit [7:0] d;
        @(negedge clk);
        hsync = 1'b1;
        if (do_wr) begin
            a = int'($urandom % 174);
            d = (a < 160) ? 8'($urandom % 10) : 8'($urandom);
            cpu_we = 1'b1; cpu_addr = 8'(a); cpu_wdata = d;
            model_write(a, d);
        end
        @(posedge clk); @(negedge clk);
        cpu_we = 1'b0;
        check(dot_en == 1'b1, "R5 first hsync clock", int'(dot_en), 1);
        @(posedge clk); @(negedge clk);
        check(dot_en == 1'b0, "R5 stop", int'(dot_en), 0);
        @(posedge clk); @(negedge clk);
        hsync = 1'b0;
        @(posedge clk); @(negedge clk);
        check(dot_en == 1'b1, "R5 restart", int'(dot_en), 1);
        check(pix_fg == 1'b0, "R11 gap", int'(pix_fg), 0);
        for (int dd = 0; dd < LDOTS; dd++) begin
            @(posedge clk); @(negedge clk);
            exp = expect_pix(line, dd, tag);
            act = {28'd0, pix_fg, pix_color};
            check(act == exp, tag, act, exp);
        end
    endtask

    task automatic run_frame(int nl, bit do_wr);
        for (int l = 0; l < nl; l++) drive_line(l, do_wr);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        void'($urandom(32'd5821));
        for (int i = 0; i < 160; i++) begin b_ram[i] = 0; f_ram[i] = 0; end
        for (int i = 0; i < 8; i++)   begin b_col[i] = 0; f_col[i] = 0; end
        for (int i = 0; i < 6; i++)   begin b_reg[i] = 0; f_reg[i] = 0; end

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(dot_en == 1'b0, "R10 reset dot_en", int'(dot_en), 0);
        check(pix_fg == 1'b0, "R10 reset pix_fg", int'(pix_fg), 0);
        check(pix_color == 3'd0, "R10 reset pix_color", int'(pix_color), 0);
        rst_n = 1'b1;

        // Screen A in the shadow; display still disabled from reset.
        for (int i = 0; i < 160; i++) cpu_write(i, 8'($urandom % 10));
        for (int r = 0; r < 8; r++)   cpu_write(160 + r, 8'(1 + $urandom % 7));
        cpu_write(168, 8'h0B);
        cpu_write(169, 8'($urandom % 220));
        cpu_write(170, 8'($urandom % 8));
        cpu_write(171, 8'd5);
        cpu_write(172, 8'd2);
        cpu_write(173, 8'd1);
        run_frame(3, 1'b0);                 // R8 before first frame load

        // Frame 1 with a write on every line (R9).
        do_vsync();
        ferr = 0;
        run_frame(NLINES, 1'b1);
        check(ferr == 0, "R9 frame unaffected by writes", ferr, 0);

        // Frame 2: threshold 0 on row 7, larger offsets.
        cpu_write(168, 8'h0F);
        cpu_write(169, 8'd0);
        cpu_write(170, 8'd6);
        cpu_write(171, 8'd10);
        cpu_write(172, 8'd4);
        cpu_write(173, 8'd1);
        do_vsync();
        run_frame(NLINES, 1'b0);

        // Frame 3: new screen, window at origin, threshold past the window.
        for (int i = 0; i < 160; i++) cpu_write(i, 8'($urandom % 12));
        for (int r = 0; r < 8; r++)   cpu_write(160 + r, 8'($urandom % 8));
        cpu_write(168, 8'h08);
        cpu_write(169, 8'd255);
        cpu_write(171, 8'd0);
        cpu_write(172, 8'd0);
        do_vsync();
        run_frame(NLINES, 1'b0);

        // Frame 4: display disabled.
        cpu_write(173, 8'd0);
        do_vsync();
        run_frame(20, 1'b0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule